// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock Unit

This unit is the hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source register numbers of the instructions in decode and execute. It compares them with the destination register, write enable and load flag of the instructions further down the pipe. From that comparison it steers the operand multiplexers and decides whether the front of the pipe must wait.

An instruction in execute can take its operands from three places. It can use the result held in the EX/MEM register, the result held in the MEM/WB register, or the value it read from the register file. The nearest producer wins. A source read in decode while the same register is being written back takes the write data directly, which models a register file that writes early in the cycle and reads late. A load in execute whose destination is needed by the instruction in decode cannot be forwarded in time. For that case the unit holds the program counter and the IF/ID register for one cycle and clears the control bits entering ID/EX, so a no-op bubble moves on in place of the instruction. After that cycle the loaded value reaches the consumer through the MEM/WB path. Register 0 is hard-wired and never takes part in any of this.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the memory-stage instruction writes (memRegWrite=1) a nonzero register equal to an execute source, that operand's select is 2'b10 (EX/MEM result).
- R2: When only the writeback-stage instruction writes (wbRegWrite=1) a nonzero register equal to an execute source, that operand's select is 2'b01 (MEM/WB result).
- R3: When both stages match the same execute source, the select is 2'b10; the code 2'b11 never appears; with no match the select is 2'b00 (register-file value).
- R4: A source or destination of register 0 never produces a nonzero select, a decode bypass or a stall.
- R5: A decode source equal to a nonzero writeback destination with wbRegWrite=1 raises that source's bypass bit (idBypassA for the first source, idBypassB for the second).
- R6: When execute holds a load (exMemRead=1, exRegWrite=1) whose nonzero destination equals either decode source, holdFront and bubbleIdEx are both 1 in that same cycle.
- R7: Without such a match (a load to an unused register, or a producer that is not a load), holdFront and bubbleIdEx are 0.
- R8: A producer with its write enable low is never forwarded or bypassed, even when its register number matches.
- R9: In a load followed by a dependent instruction, exactly one stall cycle occurs. When the consumer later reaches execute with the load in writeback, its select is 2'b01 and no further stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rstN | input | 1 | Active-low reset; the property checks are off while it is low |
| idRs1 | input | ADDR_W | First source register of the decode instruction |
| idRs2 | input | ADDR_W | Second source register of the decode instruction |
| exRs1 | input | ADDR_W | First source register of the execute instruction |
| exRs2 | input | ADDR_W | Second source register of the execute instruction |
| exRd | input | ADDR_W | Destination register of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| memRd | input | ADDR_W | Destination register of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | ADDR_W | Destination register of the writeback instruction |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| fwdSelA | output | 2 | First ALU operand source: 00 register, 01 MEM/WB, 10 EX/MEM |
| fwdSelB | output | 2 | Second ALU operand source, same encoding |
| idBypassA | output | 1 | First decode read takes the writeback data |
| idBypassB | output | 1 | Second decode read takes the writeback data |
| holdFront | output | 1 | Hold the PC and the IF/ID register |
| bubbleIdEx | output | 1 | Clear the control bits loaded into ID/EX |

## Verification
Forwarding into execute and the load-use stall decision for decode are worked out from the same cycle's stage fields. A load in execute can therefore stall the decode instruction while an older result is forwarded to the execute operands. The random stimulus draws register numbers from a small range so that both events often fall in one cycle. Every output is then compared with bench functions that treat the two decisions separately. A directed sequence walks a load and its consumer through the stall and checks that the stall lasts exactly one cycle and is followed by forwarding from writeback.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic holdFront;
    logic bubbleIdEx;
  } stallStrobes_t;

endpackage

// File: rtl/src_match.sv
module src_match #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] srcReg,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  output hazard_pkg::fwdSel_e sel
);
  import hazard_pkg::*;

  logic srcLive;
  logic memHit;
  logic wbHit;

  assign srcLive = (srcReg != '0);
  assign memHit  = srcLive && memRegWrite && (memRd == srcReg);
  assign wbHit   = srcLive && wbRegWrite && (wbRd == srcReg);

  // the younger producer in EX/MEM takes priority
  always_comb begin
    if (memHit)     sel = FWD_MEM;
    else if (wbHit) sel = FWD_WB;
    else            sel = FWD_NONE;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] exSrc,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] idSrc,
  input  logic [ADDR_W-1:0]              memRd,
  input  logic                           memRegWrite,
  input  logic [ADDR_W-1:0]              wbRd,
  input  logic                           wbRegWrite,
  output logic [NUM_SRC-1:0][1:0]        fwdSel,
  output logic [NUM_SRC-1:0]             idBypass
);
  import hazard_pkg::*;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    fwdSel_e selE;

    src_match #(.ADDR_W(ADDR_W)) u_match (
      .srcReg     (exSrc[g]),
      .memRd      (memRd),
      .memRegWrite(memRegWrite),
      .wbRd       (wbRd),
      .wbRegWrite (wbRegWrite),
      .sel        (selE)
    );

    assign fwdSel[g] = selE;

    // register file written early in the cycle, read late
    assign idBypass[g] = wbRegWrite && (wbRd != '0) && (wbRd == idSrc[g]);

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      fwdSel[g] != 2'b11);                                               // R3
    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
      (exSrc[g] == '0) |-> (fwdSel[g] == 2'b00));                        // R4
    AST_MEM_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
      (memRegWrite && memRd != '0 && memRd == exSrc[g]) |-> (fwdSel[g] == 2'b10)); // R1
    AST_WB_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      (fwdSel[g] == 2'b01) |-> (wbRegWrite && wbRd == exSrc[g]));        // R2
    AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      idBypass[g] |-> (wbRegWrite && idSrc[g] != '0));                   // R5
  end

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl #(
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] idSrc,
  input  logic [ADDR_W-1:0]              exRd,
  input  logic                           exRegWrite,
  input  logic                           exMemRead,
  output hazard_pkg::stallStrobes_t      strobes
);
  import hazard_pkg::*;

  logic              loadLive;
  logic [NUM_SRC-1:0] useHit;
  logic              loadUse;

  assign loadLive = exMemRead && exRegWrite && (exRd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gUse
    assign useHit[g] = loadLive && (idSrc[g] == exRd);
  end

  assign loadUse = |useHit;

  always_comb begin
    strobes            = '0;
    strobes.holdFront  = loadUse;
    strobes.bubbleIdEx = loadUse;
  end

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdFront |-> (exMemRead && exRegWrite));                    // R6
  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0) |-> !strobes.holdFront);                                // R4
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRead |-> !strobes.bubbleIdEx);                                 // R7

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic [ADDR_W-1:0] exRs1,
  input  logic [ADDR_W-1:0] exRs2,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exMemRead,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              idBypassA,
  output logic              idBypassB,
  output logic              holdFront,
  output logic              bubbleIdEx
);
  import hazard_pkg::*;

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][ADDR_W-1:0] exSrc;
  logic [NUM_SRC-1:0][ADDR_W-1:0] idSrc;
  logic [NUM_SRC-1:0][1:0]        fwdSel;
  logic [NUM_SRC-1:0]             idBypass;
  stallStrobes_t                  strobes;

  assign exSrc = {exRs2, exRs1};
  assign idSrc = {idRs2, idRs1};

  fwd_unit #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_fwd (
    .clk        (clk),
    .rstN       (rstN),
    .exSrc      (exSrc),
    .idSrc      (idSrc),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .fwdSel     (fwdSel),
    .idBypass   (idBypass)
  );

  stall_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_stall (
    .clk       (clk),
    .rstN      (rstN),
    .idSrc     (idSrc),
    .exRd      (exRd),
    .exRegWrite(exRegWrite),
    .exMemRead (exMemRead),
    .strobes   (strobes)
  );

  assign fwdSelA    = fwdSel[0];
  assign fwdSelB    = fwdSel[1];
  assign idBypassA  = idBypass[0];
  assign idBypassB  = idBypass[1];
  assign holdFront  = strobes.holdFront;
  assign bubbleIdEx = strobes.bubbleIdEx;

  AST_STALL_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    holdFront == bubbleIdEx);                                            // R6
  AST_WB_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!wbRegWrite && !memRegWrite) |-> (fwdSelA == 2'b00 && fwdSelB == 2'b00)); // R8

endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
  localparam int AW = 5;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exRegWrite, exMemRead, memRegWrite, wbRegWrite;
  logic [1:0] fwdSelA, fwdSelB;
  logic idBypassA, idBypassB, holdFront, bubbleIdEx;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pipe_hazard_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .idBypassA(idBypassA), .idBypassB(idBypassB),
    .holdFront(holdFront), .bubbleIdEx(bubbleIdEx)
  );

  function automatic logic [1:0] expSel(logic [AW-1:0] s, logic [AW-1:0] mRd,
                                        logic mW, logic [AW-1:0] wRd, logic wW);
    if (s == 0) return 2'b00;
    if (mW && mRd == s) return 2'b10;
    if (wW && wRd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expByp(logic [AW-1:0] s, logic [AW-1:0] wRd, logic wW);
    return wW && wRd != 0 && wRd == s;
  endfunction

  function automatic logic expStall(logic [AW-1:0] a, logic [AW-1:0] b,
                                    logic [AW-1:0] rd, logic mr, logic rw);
    return mr && rw && rd != 0 && (rd == a || rd == b);
  endfunction

  function automatic string selTag(logic [AW-1:0] s, logic [AW-1:0] mRd,
                                   logic mW, logic [AW-1:0] wRd, logic wW);
    if (s == 0) return "R4";
    if (mW && mRd == s && wW && wRd == s) return "R3";
    if (mW && mRd == s) return "R1";
    if (wW && wRd == s) return "R2";
    if (mRd == s || wRd == s) return "R8";
    return "R3";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [AW-1:0] i1, logic [AW-1:0] i2, logic [AW-1:0] e1,
                       logic [AW-1:0] e2, logic [AW-1:0] eRd, logic eW, logic eM,
                       logic [AW-1:0] mRd, logic mW, logic [AW-1:0] wRd, logic wW);
    idRs1 = i1; idRs2 = i2; exRs1 = e1; exRs2 = e2; exRd = eRd;
    exRegWrite = eW; exMemRead = eM; memRd = mRd; memRegWrite = mW;
    wbRd = wRd; wbRegWrite = wW;
  endtask

  task automatic checkAll();
    string t;
    logic s;
    #2;
    check(selTag(exRs1, memRd, memRegWrite, wbRd, wbRegWrite), 8'(fwdSelA),
          8'(expSel(exRs1, memRd, memRegWrite, wbRd, wbRegWrite)), "fwdSelA");
    check(selTag(exRs2, memRd, memRegWrite, wbRd, wbRegWrite), 8'(fwdSelB),
          8'(expSel(exRs2, memRd, memRegWrite, wbRd, wbRegWrite)), "fwdSelB");
    t = (idRs1 == 0) ? "R4" : (wbRegWrite ? "R5" : "R8");
    check(t, 8'(idBypassA), 8'(expByp(idRs1, wbRd, wbRegWrite)), "idBypassA");
    t = (idRs2 == 0) ? "R4" : (wbRegWrite ? "R5" : "R8");
    check(t, 8'(idBypassB), 8'(expByp(idRs2, wbRd, wbRegWrite)), "idBypassB");
    s = expStall(idRs1, idRs2, exRd, exMemRead, exRegWrite);
    t = s ? "R6" : ((exRd == 0) ? "R4" : "R7");
    check(t, 8'(holdFront), 8'(s), "holdFront");
    check(t, 8'(bubbleIdEx), 8'(s), "bubbleIdEx");
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    // reset state with idle inputs
    #2;
    check("R3", 8'(fwdSelA), 8'd0, "reset fwdSelA");
    check("R7", 8'(holdFront), 8'd0, "reset holdFront");
    @(negedge clk); rstN = 1;

    // directed corner cases
    @(negedge clk); drive(0, 0, 3, 4, 0, 0, 0, 3, 1, 4, 1); checkAll();     // R1 / R2
    @(negedge clk); drive(0, 0, 7, 7, 0, 0, 0, 7, 1, 7, 1); checkAll();     // R3
    @(negedge clk); drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1); checkAll();     // R4
    @(negedge clk); drive(0, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0); checkAll();     // R4
    @(negedge clk); drive(6, 2, 6, 2, 0, 0, 0, 6, 0, 2, 0); checkAll();     // R8
    @(negedge clk); drive(5, 6, 1, 1, 5, 1, 1, 0, 0, 6, 1); checkAll();     // R5 R6
    @(negedge clk); drive(1, 2, 1, 1, 5, 1, 1, 0, 0, 0, 0); checkAll();     // R7 unused dest
    @(negedge clk); drive(5, 2, 1, 1, 5, 1, 0, 0, 0, 0, 0); checkAll();     // R7 non-load

    // R9: lw r5 then add uses r5; bench steps the stage fields itself
    @(negedge clk); drive(5, 1, 0, 0, 5, 1, 1, 0, 0, 0, 0); #2;
    check("R9", 8'(holdFront), 8'd1, "stall cycle 1");
    // held decode, bubble in EX, load in MEM
    @(negedge clk); drive(5, 1, 0, 0, 0, 0, 0, 5, 1, 0, 0); #2;
    check("R9", 8'(holdFront), 8'd0, "no second stall");
    // consumer in EX, bubble in MEM, load in WB
    @(negedge clk); drive(0, 0, 5, 1, 8, 1, 0, 0, 0, 5, 1); #2;
    check("R9", 8'(fwdSelA), 8'b01, "load value from MEM/WB");
    check("R9", 8'(holdFront), 8'd0, "consumer not stalled");

    // constrained random: small register range provokes collisions
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      drive(AW'($urandom % 6), AW'($urandom % 6), AW'($urandom % 6), AW'($urandom % 6),
            AW'($urandom % 6), 1'($urandom), 1'($urandom), AW'($urandom % 6),
            1'($urandom), AW'($urandom % 6), 1'($urandom));
      checkAll();
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule